// File: doc/BRIEF.md
# Repartitionable Vector Register File

This block holds the data registers of a vector unit in a fixed pool of 128 elements of 64 bits (1 KB). A configuration input chooses how that pool is split. Four splits are available: many short registers, or fewer long ones. The maximum vector length (MVL) follows from the split, and is never below four elements. A vector-length request port clamps a requested element count to MVL. It returns the granted length at once and stores it in a vector-length register. A strip-mined loop can therefore run its last, partial pass with the same code as the full passes.

The block has two element read ports and one element write port. Each port addresses an element by register index and element index. Any index outside the active split is rejected. A write to an element at or beyond the current vector length is dropped without an error. A separate bank of eight predicate masks sits beside the data registers.

Top module: `vrf_part`

## Requirements
- R1: After reset the split is mode 0: `nregs_out` = 32, `mvl_out` = 4 and `vl_out` = 0. All predicate masks read 0.
- R2: When `cfg_load` is high at a clock edge, `cfg_mode` = m is taken. From the next cycle `nregs_out` = 32 >> m and `mvl_out` = 4 << m, so their product is always 128.
- R3: `setvl_grant` is min(`mvl_out`, `setvl_avl`) in the same cycle. When `setvl_req` is high at an edge and `cfg_load` is low, `vl_out` takes that grant from the next cycle. Otherwise `vl_out` holds.
- R4: A requested count of 0 grants 0 and sets `vl_out` to 0.
- R5: `cfg_load` clears `vl_out` to 0 in the next cycle. It wins over a `setvl_req` given in the same cycle.
- R6: Every (register, element) pair inside the active split holds its own 64-bit value. The value is stored at physical slot register × MVL + element. A write is visible on both read ports from the next cycle.
- R7: A write with register index ≥ `nregs_out` or element index ≥ `mvl_out` raises `wr_err` in the same cycle and changes no storage. This holds even where the computed slot would fall into another register.
- R8: A write with valid indices but element index ≥ `vl_out` gives no error and changes no storage.
- R9: Each read port is combinational. An out-of-range register or element index raises that port's error flag and returns data 0.
- R10: There are eight 32-bit predicate masks, selected by a 3-bit index. A mask write is visible on the predicate read port from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Apply `cfg_mode` at this edge |
| cfg_mode | input | 2 | Split select: 32>>m registers of 4<<m elements |
| nregs_out | output | 6 | Enabled register count |
| mvl_out | output | 6 | Maximum vector length |
| setvl_req | input | 1 | Load the vector-length register |
| setvl_avl | input | 16 | Requested element count |
| setvl_grant | output | 6 | Clamped length for the current request |
| vl_out | output | 6 | Current vector length |
| wr_en | input | 1 | Element write strobe |
| wr_reg | input | 5 | Write register index |
| wr_elem | input | 5 | Write element index |
| wr_data | input | 64 | Write data |
| wr_err | output | 1 | Write index out of range |
| rda_reg | input | 5 | Read port A register index |
| rda_elem | input | 5 | Read port A element index |
| rda_data | output | 64 | Read port A data |
| rda_err | output | 1 | Read port A index out of range |
| rdb_reg | input | 5 | Read port B register index |
| rdb_elem | input | 5 | Read port B element index |
| rdb_data | output | 64 | Read port B data |
| rdb_err | output | 1 | Read port B index out of range |
| pw_en | input | 1 | Predicate write strobe |
| pw_idx | input | 3 | Predicate write index |
| pw_data | input | 32 | Predicate write mask |
| pr_idx | input | 3 | Predicate read index |
| pr_data | output | 32 | Predicate read mask |

## Verification
The assertions take for granted that `cfg_mode` is meaningful only in the cycle that `cfg_load` is high. They also take for granted that no bench reads data written under an earlier split. The stimulus rewrites every element it reads after each reconfiguration. It never relies on contents surviving a `cfg_load`, and it never issues a write in the same cycle as `cfg_load`.

// File: rtl/vrf_part.sv
module vrf_part #(
  parameter int ELEM_W   = 64,
  parameter int MAX_REGS = 32,
  parameter int MIN_MVL  = 4,
  parameter int MODE_W   = 2,
  parameter int PRED_N   = 8,
  parameter int AVL_W    = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_load,
  input  logic [MODE_W-1:0]                 cfg_mode,
  output logic [$clog2(MAX_REGS):0]         nregs_out,
  output logic [$clog2(MIN_MVL<<((1<<MODE_W)-1)):0] mvl_out,
  input  logic                              setvl_req,
  input  logic [AVL_W-1:0]                  setvl_avl,
  output logic [$clog2(MIN_MVL<<((1<<MODE_W)-1)):0] setvl_grant,
  output logic [$clog2(MIN_MVL<<((1<<MODE_W)-1)):0] vl_out,
  input  logic                              wr_en,
  input  logic [$clog2(MAX_REGS)-1:0]       wr_reg,
  input  logic [$clog2(MIN_MVL<<((1<<MODE_W)-1))-1:0] wr_elem,
  input  logic [ELEM_W-1:0]                 wr_data,
  output logic                              wr_err,
  input  logic [$clog2(MAX_REGS)-1:0]       rda_reg,
  input  logic [$clog2(MIN_MVL<<((1<<MODE_W)-1))-1:0] rda_elem,
  output logic [ELEM_W-1:0]                 rda_data,
  output logic                              rda_err,
  input  logic [$clog2(MAX_REGS)-1:0]       rdb_reg,
  input  logic [$clog2(MIN_MVL<<((1<<MODE_W)-1))-1:0] rdb_elem,
  output logic [ELEM_W-1:0]                 rdb_data,
  output logic                              rdb_err,
  input  logic                              pw_en,
  input  logic [$clog2(PRED_N)-1:0]         pw_idx,
  input  logic [(MIN_MVL<<((1<<MODE_W)-1))-1:0] pw_data,
  input  logic [$clog2(PRED_N)-1:0]         pr_idx,
  output logic [(MIN_MVL<<((1<<MODE_W)-1))-1:0] pr_data
);
  localparam int MAX_MVL = MIN_MVL << ((1 << MODE_W) - 1);
  localparam int TOTAL   = MAX_REGS * MIN_MVL;
  localparam int ADDR_W  = $clog2(TOTAL);
  localparam int REG_W   = $clog2(MAX_REGS);
  localparam int EIX_W   = $clog2(MAX_MVL);
  localparam int VL_W    = EIX_W + 1;
  localparam int MIN_SH  = $clog2(MIN_MVL);

  logic [MODE_W-1:0] mode_q;
  logic [VL_W-1:0]   vl_q;
  logic [ELEM_W-1:0] mem [TOTAL];
  logic [MAX_MVL-1:0] pred [PRED_N];

  assign nregs_out = (REG_W+1)'(MAX_REGS) >> mode_q;
  assign mvl_out   = VL_W'(MIN_MVL) << mode_q;
  assign vl_out    = vl_q;

  function automatic logic in_range(input logic [REG_W-1:0] r, input logic [EIX_W-1:0] e);
    return ({1'b0, r} < nregs_out) && ({1'b0, e} < mvl_out);
  endfunction

  function automatic logic [ADDR_W-1:0] slot(input logic [REG_W-1:0] r, input logic [EIX_W-1:0] e);
    return (ADDR_W'(r) << (MIN_SH + int'(mode_q))) + ADDR_W'(e);
  endfunction

  assign setvl_grant = (setvl_avl >= AVL_W'(mvl_out)) ? mvl_out : setvl_avl[VL_W-1:0];

  logic wr_ok, wr_do;
  assign wr_ok  = in_range(wr_reg, wr_elem);
  assign wr_err = wr_en & ~wr_ok;
  assign wr_do  = wr_en & wr_ok & ({1'b0, wr_elem} < vl_q) & ~cfg_load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      vl_q   <= '0;
    end else if (cfg_load) begin
      mode_q <= cfg_mode;
      vl_q   <= '0;
    end else if (setvl_req) begin
      vl_q   <= setvl_grant;
    end
  end

  always_ff @(posedge clk)
    if (wr_do) mem[slot(wr_reg, wr_elem)] <= wr_data;

  assign rda_err  = ~in_range(rda_reg, rda_elem);
  assign rdb_err  = ~in_range(rdb_reg, rdb_elem);
  assign rda_data = rda_err ? '0 : mem[slot(rda_reg, rda_elem)];
  assign rdb_data = rdb_err ? '0 : mem[slot(rdb_reg, rdb_elem)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PRED_N; i++) pred[i] <= '0;
    end else if (pw_en) begin
      pred[pw_idx] <= pw_data;
    end
  end

  assign pr_data = pred[pr_idx];
endmodule

// File: rtl/vrf_part_chk.sv
module vrf_part_chk #(
  parameter int MAX_REGS = 32,
  parameter int MIN_MVL  = 4,
  parameter int MODE_W   = 2,
  parameter int AVL_W    = 16,
  parameter int ELEM_W   = 64
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cfg_load,
  input logic [$clog2(MAX_REGS):0]   nregs_out,
  input logic [$clog2(MIN_MVL<<((1<<MODE_W)-1)):0] mvl_out,
  input logic                        setvl_req,
  input logic [AVL_W-1:0]            setvl_avl,
  input logic [$clog2(MIN_MVL<<((1<<MODE_W)-1)):0] setvl_grant,
  input logic [$clog2(MIN_MVL<<((1<<MODE_W)-1)):0] vl_out,
  input logic                        wr_en,
  input logic [$clog2(MAX_REGS)-1:0] wr_reg,
  input logic                        wr_err,
  input logic                        rda_err,
  input logic [ELEM_W-1:0]           rda_data
);
  AST_VL_BOUND:     assert property (@(posedge clk) disable iff (!rst_n) vl_out <= mvl_out); // R3
  AST_MVL_FLOOR:    assert property (@(posedge clk) disable iff (!rst_n) mvl_out >= MIN_MVL); // R2
  AST_CFG_ZERO_VL:  assert property (@(posedge clk) disable iff (!rst_n) cfg_load |=> vl_out == 0); // R5
  AST_SETVL_TAKEN:  assert property (@(posedge clk) disable iff (!rst_n) (setvl_req && !cfg_load) |=> vl_out == $past(setvl_grant)); // R3
  AST_VL_HOLD:      assert property (@(posedge clk) disable iff (!rst_n) (!setvl_req && !cfg_load) |=> vl_out == $past(vl_out)); // R3
  AST_ZERO_AVL:     assert property (@(posedge clk) disable iff (!rst_n) (setvl_avl == 0) |-> setvl_grant == 0); // R4
  AST_WR_BAD_REG:   assert property (@(posedge clk) disable iff (!rst_n) (wr_en && ({1'b0, wr_reg} >= nregs_out)) |-> wr_err); // R7
  AST_RD_ERR_ZERO:  assert property (@(posedge clk) disable iff (!rst_n) rda_err |-> rda_data == 0); // R9
endmodule

bind vrf_part vrf_part_chk #(
  .MAX_REGS(MAX_REGS), .MIN_MVL(MIN_MVL), .MODE_W(MODE_W), .AVL_W(AVL_W), .ELEM_W(ELEM_W)
) u_chk (.*);

// File: tb/tb_vrf_part.sv
module tb_vrf_part;
  logic clk = 0, rst_n = 0;
  logic cfg_load = 0; logic [1:0] cfg_mode = 0;
  logic [5:0] nregs_out, mvl_out, setvl_grant, vl_out;
  logic setvl_req = 0; logic [15:0] setvl_avl = 0;
  logic wr_en = 0; logic [4:0] wr_reg = 0, wr_elem = 0; logic [63:0] wr_data = 0; logic wr_err;
  logic [4:0] rda_reg = 0, rda_elem = 0, rdb_reg = 0, rdb_elem = 0;
  logic [63:0] rda_data, rdb_data; logic rda_err, rdb_err;
  logic pw_en = 0; logic [2:0] pw_idx = 0, pr_idx = 0; logic [31:0] pw_data = 0, pr_data;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  vrf_part dut (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); #1; endtask

  task automatic do_cfg(input int m);
    cfg_mode = 2'(m); cfg_load = 1; tick; cfg_load = 0;
  endtask

  task automatic do_setvl(input int avl, input int exp);
    setvl_avl = 16'(avl); setvl_req = 1; #1;
    check(setvl_grant == 6'(exp), "R3 grant", 64'(setvl_grant), 64'(exp));
    tick; setvl_req = 0;
    check(vl_out == 6'(exp), "R3 vl", 64'(vl_out), 64'(exp));
  endtask

  task automatic do_wr(input int r, input int e, input logic [63:0] d, input bit exp_err, input string req);
    wr_reg = 5'(r); wr_elem = 5'(e); wr_data = d; wr_en = 1; #1;
    check(wr_err == exp_err, req, 64'(wr_err), 64'(exp_err));
    tick; wr_en = 0;
  endtask

  task automatic rd_a(input int r, input int e, input logic [63:0] exp, input bit exp_err, input string req);
    rda_reg = 5'(r); rda_elem = 5'(e); #1;
    check(rda_err == exp_err && rda_data == exp, req, rda_data, exp);
  endtask

  task automatic rd_b(input int r, input int e, input logic [63:0] exp, input string req);
    rdb_reg = 5'(r); rdb_elem = 5'(e); #1;
    check(!rdb_err && rdb_data == exp, req, rdb_data, exp);
  endtask

  function automatic logic [63:0] pat(input int r, input int e);
    return 64'hC3A5_0000_0000_0000 ^ {48'd0, 8'(r), 8'(e)};
  endfunction

  task automatic t_reset;
    check(nregs_out == 32, "R1 nregs", 64'(nregs_out), 64'd32);
    check(mvl_out == 4, "R1 mvl", 64'(mvl_out), 64'd4);
    check(vl_out == 0, "R1 vl", 64'(vl_out), 64'd0);
    pr_idx = 3'd5; #1;
    check(pr_data == 0, "R1 pred", 64'(pr_data), 64'd0);
  endtask

  task automatic t_modes;
    for (int m = 3; m >= 0; m--) begin
      do_cfg(m);
      check(nregs_out == 6'(32 >> m), "R2 nregs", 64'(nregs_out), 64'(32 >> m));
      check(mvl_out == 6'(4 << m), "R2 mvl", 64'(mvl_out), 64'(4 << m));
    end
  endtask

  task automatic t_setvl;
    for (int m = 0; m < 4; m++) begin
      int mv = 4 << m;
      do_cfg(m);
      do_setvl(1, 1);
      do_setvl(mv - 1, mv - 1);
      do_setvl(mv, mv);
      do_setvl(mv + 1, mv);
      do_setvl(1000, mv);
      do_setvl(0, 0); // R4
      check(vl_out == 0, "R4 zero", 64'(vl_out), 64'd0);
    end
  endtask

  task automatic t_cfg_prio;
    do_cfg(1); do_setvl(5, 5);
    cfg_mode = 2'd1; cfg_load = 1; setvl_avl = 16'd3; setvl_req = 1; tick;
    cfg_load = 0; setvl_req = 0;
    check(vl_out == 0, "R5 priority", 64'(vl_out), 64'd0);
    do_setvl(6, 6);
    do_cfg(1);
    check(vl_out == 0, "R5 clear", 64'(vl_out), 64'd0);
  endtask

  task automatic t_fill(input int m);
    int nr = 32 >> m, mv = 4 << m;
    do_cfg(m); do_setvl(mv, mv);
    for (int r = 0; r < nr; r++)
      for (int e = 0; e < mv; e++) do_wr(r, e, pat(r, e), 1'b0, "R6 wr_err");
    for (int r = 0; r < nr; r++)
      for (int e = 0; e < mv; e++) begin
        rd_a(r, e, pat(r, e), 1'b0, "R6 port A");
        rd_b(r, e, pat(r, e), "R6 port B");
      end
  endtask

  task automatic t_bad_write;
    // mode 1: 16 regs x 8; v16 e0 would wrap onto v0 e0, v0 e8 onto v1 e0
    t_fill(1);
    do_wr(16, 0, 64'hDEAD, 1'b1, "R7 bad reg err");
    rd_a(0, 0, pat(0, 0), 1'b0, "R7 v0e0 intact");
    do_wr(0, 8, 64'hBEEF, 1'b1, "R7 bad elem err");
    rd_a(1, 0, pat(1, 0), 1'b0, "R7 v1e0 intact");
  endtask

  task automatic t_vl_suppress;
    do_setvl(3, 3);
    do_wr(2, 5, 64'h1234, 1'b0, "R8 no err");
    rd_a(2, 5, pat(2, 5), 1'b0, "R8 suppressed");
    do_wr(2, 2, 64'h5678, 1'b0, "R8 below vl err");
    rd_a(2, 2, 64'h5678, 1'b0, "R8 below vl written");
  endtask

  task automatic t_read_err;
    rd_a(20, 0, 64'd0, 1'b1, "R9 bad reg");
    rd_a(0, 9, 64'd0, 1'b1, "R9 bad elem");
    rdb_reg = 5'd31; rdb_elem = 5'd0; #1;
    check(rdb_err && rdb_data == 0, "R9 port B", rdb_data, 64'd0);
  endtask

  task automatic t_pred;
    for (int i = 0; i < 8; i++) begin
      pw_idx = 3'(i); pw_data = 32'h0F0F_0000 | 32'(i * 17); pw_en = 1; tick;
    end
    pw_en = 0;
    for (int i = 0; i < 8; i++) begin
      pr_idx = 3'(i); #1;
      check(pr_data == (32'h0F0F_0000 | 32'(i * 17)), "R10 pred", 64'(pr_data), 64'(32'h0F0F_0000 | 32'(i * 17)));
    end
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick; tick; rst_n = 1; tick;
    t_reset;
    t_modes;
    t_setvl;
    t_cfg_prio;
    t_fill(0);
    t_fill(3);
    t_bad_write;
    t_vl_suppress;
    t_read_err;
    t_pred;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule